// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block sits on an 8-bit processor bus and gives software three 8-bit parallel ports, named A, B and C. A two-bit address picks one of the three ports or the control register. Every access is qualified by active-low chip-select, read and write strobes. Writes are taken on the rising clock edge while the strobes are held low. Reads are combinational, so a port that is set up as an input shows its pins on the bus in the same cycle.

The control register works in simple I/O mode. A control word with its top bit set is a mode word. It sets the direction of port A, port B and each half of port C, and it clears every output latch. A control word with its top bit clear is a single-bit command: it sets or clears one bit of the port C output latch and leaves everything else alone. Port C is handled as two independent nibbles. The upper nibble belongs to group A, together with port A. The lower nibble belongs to group B, together with port B.

Each pad is modelled as a separate input, output value and output enable. There is no tristate logic inside the block.

Top module: `ppi_top`

## Requirements
- R1: With cs_n=0 and wr_n=0 at a rising clock edge, din is written to the target selected by addr: 00 is the port A latch, 01 is the port B latch, 10 is the port C latch and 11 is the control register.
- R2: While cs_n=1, no write takes effect and dout_oe stays low, whatever rd_n, wr_n, addr and din are.
- R3: After rst (synchronous, active high), every output latch is 0x00, every output enable is low, and the control register reads back 0x9B (all ports input).
- R4: pa_out, pb_out and pc_out always show their latch values, which are held until the next write. A port latch is written even while that port is an input.
- R5: A control write with din[7]=1 stores the full word as the mode and clears all three output latches to 0x00.
- R6: Mode bits choose direction, with 1 meaning input: bit 4 sets port A, bit 3 sets port C bits 7..4, bit 1 sets port B and bit 0 sets port C bits 3..0. An output group has its enables all ones and an input group has them all zeros. Mode bits 6, 5 and 2 have no effect on any port.
- R7: A control write with din[7]=0 forces port C latch bit din[3:1] to din[0]. All other latch bits, the stored mode and all enables stay the same, and din[6:4] has no effect.
- R8: dout_oe is high exactly when cs_n=0, rd_n=0 and wr_n=1. dout is 0x00 whenever dout_oe is low. A read at addr 11 returns the last stored mode word.
- R9: Reading a port, or a port C nibble, that is set as input returns its live pins with no latching, and a pin change appears on dout within the same cycle. Reading an output group returns its latch.
- R10: The two nibbles of port C have independent directions. A read of port C combines the pins of the input nibble with the latch of the output nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target select: 00 A, 01 B, 10 C, 11 control |
| din | input | 8 | Write data from the processor bus |
| dout | output | 8 | Read data to the processor bus |
| dout_oe | output | 1 | Drive enable for the processor data bus |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Directed sequences first exercise all-output, all-input and mixed-nibble mode words. Comparing the readback of these three separates the latch path from the pin path on each group, and separates the two nibbles of port C from each other. Single-bit commands then target the lowest, the highest and a middle bit of port C, with junk in the ignored field, which exposes any error in bit selection or in masking. A pin change in the middle of a read shows whether the input path is latched. A long pseudo-random run of strobes, addresses and data, including accesses with chip-select high and reads that overlap writes, is checked every cycle against a behavioural model.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DW  = 8;
  localparam int NIB = DW / 2;
  localparam int SELW = $clog2(DW);

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  localparam int FLAG_BIT  = 7;
  localparam int DIR_A_BIT = 4;
  localparam int DIR_CH_BIT = 3;
  localparam int DIR_B_BIT = 1;
  localparam int DIR_CL_BIT = 0;
  localparam logic [DW-1:0] MODE_RST = 8'h9B;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic ch_in;
    logic cl_in;
  } dir_t;

  function automatic logic is_mode_word(input logic [DW-1:0] w);
    return w[FLAG_BIT];
  endfunction

  function automatic dir_t decode_dir(input logic [DW-1:0] m);
    dir_t d;
    d.a_in  = m[DIR_A_BIT];
    d.b_in  = m[DIR_B_BIT];
    d.ch_in = m[DIR_CH_BIT];
    d.cl_in = m[DIR_CL_BIT];
    return d;
  endfunction

  function automatic logic [DW-1:0] bit_cmd_mask(input logic [DW-1:0] w);
    logic [DW-1:0] m;
    m = '0;
    m[w[SELW:1]] = 1'b1;
    return m;
  endfunction

  function automatic logic bit_cmd_value(input logic [DW-1:0] w);
    return w[0];
  endfunction
endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if
  import ppi_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_c,
  output logic       wr_ctl,
  output logic       rd_en,
  output sel_e       rd_sel
);
  logic wr_any;

  assign wr_any = !cs_n && !wr_n;
  assign rd_en  = !cs_n && !rd_n && wr_n;
  assign rd_sel = sel_e'(addr);

  always_comb begin
    wr_a   = 1'b0;
    wr_b   = 1'b0;
    wr_c   = 1'b0;
    wr_ctl = 1'b0;
    if (wr_any) begin
      unique case (sel_e'(addr))
        SEL_A:   wr_a   = 1'b1;
        SEL_B:   wr_b   = 1'b1;
        SEL_C:   wr_c   = 1'b1;
        SEL_CTL: wr_ctl = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] mode_q,
  output dir_t          dir,
  output logic          wr_mode,
  output logic          wr_bit,
  output logic [DW-1:0] bit_mask,
  output logic          bit_val
);
  assign wr_mode  = wr_ctl && is_mode_word(din);
  assign wr_bit   = wr_ctl && !is_mode_word(din);
  assign bit_mask = wr_bit ? bit_cmd_mask(din) : '0;
  assign bit_val  = bit_cmd_value(din);
  assign dir      = decode_dir(mode_q);

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MODE_RST;
    else if (wr_mode) mode_q <= din;
  end
endmodule

// File: rtl/ppi_port.sv
module ppi_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_all,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] bit_mask,
  input  logic         bit_val,
  input  logic         is_input,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q;
  logic [W-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (clr)         latch_d = '0;
    else if (wr_all) latch_d = wr_data;
    else begin
      for (int i = 0; i < W; i++) begin
        if (bit_mask[i]) latch_d[i] = bit_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= latch_d;
  end

  assign pin_out = latch_q;
  assign pin_oe  = is_input ? '0 : '1;
  assign rd_val  = is_input ? pin_in : latch_q;
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  logic          wr_a, wr_b, wr_c, wr_ctl, rd_en;
  sel_e          rd_sel;
  logic [DW-1:0] mode_q;
  dir_t          dir;
  logic          wr_mode, wr_bit, bit_val;
  logic [DW-1:0] bit_mask;
  logic [DW-1:0] rd_a, rd_b, rd_c;

  ppi_bus_if u_bus (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_ctl(wr_ctl),
    .rd_en(rd_en), .rd_sel(rd_sel)
  );

  ppi_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .din(din),
    .mode_q(mode_q), .dir(dir), .wr_mode(wr_mode), .wr_bit(wr_bit),
    .bit_mask(bit_mask), .bit_val(bit_val)
  );

  ppi_port #(.W(DW)) u_pa (
    .clk(clk), .rst(rst), .clr(wr_mode), .wr_all(wr_a), .wr_data(din),
    .bit_mask('0), .bit_val(1'b0), .is_input(dir.a_in),
    .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rd_a)
  );

  ppi_port #(.W(DW)) u_pb (
    .clk(clk), .rst(rst), .clr(wr_mode), .wr_all(wr_b), .wr_data(din),
    .bit_mask('0), .bit_val(1'b0), .is_input(dir.b_in),
    .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rd_b)
  );

  for (genvar h = 0; h < 2; h++) begin : g_pc_half
    localparam int LO = h * NIB;
    logic half_in;
    assign half_in = (h == 0) ? dir.cl_in : dir.ch_in;
    ppi_port #(.W(NIB)) u_half (
      .clk(clk), .rst(rst), .clr(wr_mode), .wr_all(wr_c),
      .wr_data(din[LO +: NIB]), .bit_mask(bit_mask[LO +: NIB]),
      .bit_val(bit_val), .is_input(half_in),
      .pin_in(pc_in[LO +: NIB]), .pin_out(pc_out[LO +: NIB]),
      .pin_oe(pc_oe[LO +: NIB]), .rd_val(rd_c[LO +: NIB])
    );
  end

  always_comb begin
    dout = '0;
    if (rd_en) begin
      unique case (rd_sel)
        SEL_A:   dout = rd_a;
        SEL_B:   dout = rd_b;
        SEL_C:   dout = rd_c;
        SEL_CTL: dout = mode_q;
      endcase
    end
  end
  assign dout_oe = rd_en;
endmodule

// File: rtl/ppi_sva.sv
module ppi_sva (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic [1:0] addr,
  input logic [7:0] dout,
  input logic       dout_oe,
  input logic [7:0] pa_in,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe,
  input logic       wr_mode,
  input logic       wr_bit
);
  a_r3_reset_inputs: assert property (@(posedge clk)
    $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00
                    && pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r2_no_effect_unselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)
              && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  a_r2_no_drive_unselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !dout_oe);

  a_r5_mode_clears: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r7_single_bit: assert property (@(posedge clk) disable iff (rst)
    wr_bit |=> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out)
                && $stable(pb_out) && $stable(pc_oe) && $stable(pa_oe)));

  a_r6_nibble_uniform: assert property (@(posedge clk) disable iff (rst)
    ((pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF)
     && (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF)));

  a_r9_live_pins: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && addr == 2'b00 && pa_oe == 8'h00) |-> (dout == pa_in));
endmodule

bind ppi_top ppi_sva u_sva (
  .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .dout(dout),
  .dout_oe(dout_oe), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe),
  .wr_mode(wr_mode), .wr_bit(wr_bit)
);

// File: tb/sim_ppi_top.sv
module sim_ppi_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       dout_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit started = 0;

  always #4 clk = ~clk;

  ppi_top u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // behavioural reference state
  logic [7:0] m_mode, m_a, m_b, m_c;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_mode <= 8'h9B; m_a <= 0; m_b <= 0; m_c <= 0;
    end else if (cs_n == 0 && wr_n == 0) begin
      case (addr)
        2'd0: m_a <= din;
        2'd1: m_b <= din;
        2'd2: m_c <= din;
        default: begin
          if (din[7]) begin
            m_mode <= din; m_a <= 0; m_b <= 0; m_c <= 0;
          end else begin
            m_c[din[3:1]] <= din[0];
          end
        end
      endcase
    end
  end

  function automatic logic [7:0] grp(input logic is_in, input logic [7:0] pins,
                                     input logic [7:0] lat);
    return is_in ? pins : lat;
  endfunction

  function automatic logic [7:0] exp_dout();
    logic [7:0] r;
    if (!(cs_n == 0 && rd_n == 0 && wr_n == 1)) return 8'h00;
    case (addr)
      2'd0: r = grp(m_mode[4], pa_in, m_a);
      2'd1: r = grp(m_mode[1], pb_in, m_b);
      2'd2: begin
        r[7:4] = m_mode[3] ? pc_in[7:4] : m_c[7:4];
        r[3:0] = m_mode[0] ? pc_in[3:0] : m_c[3:0];
      end
      default: r = m_mode;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R4 pa_out", pa_out, m_a);
      check("R4 pb_out", pb_out, m_b);
      check("R4 pc_out", pc_out, m_c);
      check("R6 pa_oe", pa_oe, m_mode[4] ? 8'h00 : 8'hFF);
      check("R6 pb_oe", pb_oe, m_mode[1] ? 8'h00 : 8'hFF);
      check("R10 pc_oe", pc_oe, {m_mode[3] ? 4'h0 : 4'hF, m_mode[0] ? 4'h0 : 4'hF});
      check("R8 dout_oe", {7'd0, dout_oe}, {7'd0, (cs_n == 0 && rd_n == 0 && wr_n == 1)});
      check("R9 dout", dout, exp_dout());
    end
  end

  task automatic drive(input logic c, input logic r, input logic w,
                       input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cs_n = c; rd_n = r; wr_n = w; addr = a; din = d;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    drive(0, 1, 0, a, d);
  endtask

  task automatic idle();
    drive(1, 1, 1, 2'd0, 8'h00);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    drive(0, 0, 1, a, 8'h00);
    @(negedge clk);
    check(tag, dout, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R3: reset state
    rd_chk(2'd3, 8'h9B, "R3 control after reset");
    @(negedge clk);
    check("R3 pa_oe after reset", pa_oe, 8'h00);
    check("R3 pc_out after reset", pc_out, 8'h00);
    // R1 R5 R6: all outputs
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hC3);
    wr(2'd2, 8'h96);
    idle();
    rd_chk(2'd0, 8'h5A, "R1 port A latch");
    rd_chk(2'd1, 8'hC3, "R1 port B latch");
    rd_chk(2'd2, 8'h96, "R1 port C latch");
    // R2: chip select high blocks write and drive
    drive(1, 1, 0, 2'd0, 8'hFF);
    drive(1, 0, 1, 2'd0, 8'h00);
    @(negedge clk);
    check("R2 no drive when deselected", {7'd0, dout_oe}, 8'h00);
    check("R2 port A unchanged", pa_out, 8'h5A);
    // R7: single-bit commands, junk in bits 6..4
    wr(2'd3, 8'h71);  // bit 0 -> 1
    wr(2'd3, 8'h0E);  // bit 7 -> 0
    wr(2'd3, 8'h5B);  // bit 5 -> 1
    idle();
    @(negedge clk);
    check("R7 bit commands", pc_out, 8'h37);
    rd_chk(2'd3, 8'h80, "R7 mode kept");
    // R5 R10: mixed nibbles, upper input lower output
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h88);
    idle();
    @(negedge clk);
    check("R5 latches cleared", pc_out, 8'h00);
    wr(2'd2, 8'h3C);
    pc_in = 8'hA5;
    rd_chk(2'd2, 8'hAC, "R10 mixed nibble read");
    check("R10 pc_oe", pc_oe, 8'h0F);
    // R9: live pins on an input port
    wr(2'd3, 8'h92);
    pa_in = 8'h11;
    drive(0, 0, 1, 2'd0, 8'h00);
    #1 pa_in = 8'h22;
    @(negedge clk);
    check("R9 unlatched input read", dout, 8'h22);
    // R4: write into an input port still updates the latch
    wr(2'd0, 8'h77);
    idle();
    @(negedge clk);
    check("R4 latch written while input", pa_out, 8'h77);
    check("R4 oe low while input", pa_oe, 8'h00);
    // R6: bits 6,5,2 have no effect
    wr(2'd3, 8'hE4);
    idle();
    @(negedge clk);
    check("R6 ignored mode bits", pb_oe, 8'hFF);
    rd_chk(2'd3, 8'hE4, "R8 control readback");
    // pseudo-random traffic against the model
    lf = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pa_in = lf[7:0] ^ 8'h3C;
      pb_in = lf[15:8];
      pc_in = lf[11:4];
      drive(lf[0] & lf[1], lf[2], lf[3], lf[5:4], {lf[6], lf[14:8]});
    end
    // mid-run reset
    drive(1, 1, 1, 2'd0, 8'h00);
    rst = 1;
    @(posedge clk); #1 rst = 0;
    rd_chk(2'd3, 8'h9B, "R3 control after second reset");
    idle();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule